// File: doc/BRIEF.md
# Bit-Serial Accumulator Processor Core

A compact stored-program processor in which one embedded memory holds both the program and its data. After reset the core fetches one byte-wide instruction at a time, starting at address 0, and executes the instructions in order. The registers are an accumulator A, a second operand B and a program counter. Each instruction byte carries a 4-bit operation code in its upper nibble and a 4-bit operand field in its lower nibble.

Arithmetic is done one bit per clock, least significant bit first, through a single full adder and a carry flip-flop. A subtraction leaves a zero flag and a negative flag behind. Two test instructions use these flags to skip the next instruction, and an absolute jump closes loops. The memory is loaded through a preload port while reset is held low. Any word can be read back at any time, and A, B, the program counter and a halted flag are visible as outputs.

Program words live in the lower half of the memory and data words in the upper half. The operand field of a load or a store therefore selects word 16+field, and the operand field of a jump selects a program address. A highest-proper-factor routine of 14 instructions runs at program addresses 0x0 to 0xD. It reads X from data word 0 and leaves its answer in data word 1.

Top module: `serial_acc_cpu`

## Requirements
- R1: While `rst_n` is low the core holds PC=0, A=0, B=0 and `halted`=0. A write with `load_en`=1 stores `load_data` at `load_addr` on a rising clock edge, and `peek_data` shows memory word `peek_addr` combinationally.
- R2: Opcode 0x1 (load) sets A to memory word 16+field. Opcode 0x2 (store) writes A to memory word 16+field.
- R3: Opcode 0x3 (move) copies A into B. Opcodes 0x0 and any other undefined codes do nothing.
- R4: Opcode 0x4 (decrement) sets A to A−1 modulo 256, so 0x00 becomes 0xFF.
- R5: Opcode 0x5 (subtract) sets B to B−A modulo 256 and leaves A unchanged. It sets the zero flag when the result is 0, and sets the negative flag when B<A as unsigned values (a borrow out of the last bit). After reset the zero flag is 1 and the negative flag is 0.
- R6: Opcode 0x6 skips the next instruction when the zero flag is 0.
- R7: Opcode 0x7 skips the next instruction when the negative flag is 1. An equal-operand subtraction does not count as negative.
- R8: Opcode 0x8 (jump) loads PC with the 4-bit field.
- R9: Opcode 0xF (halt) raises `halted`. From then until reset, PC, A, B and memory do not change.
- R10: A plain instruction takes 2 clocks (fetch and execute). Decrement and subtract each take 10 clocks: fetch, 8 serial bit clocks and one flag clock.
- R11: The highest-proper-factor program with X at data word 0 halts with the largest proper divisor of X in data word 1 and in A, and with B=0. For example, 21 gives 7, 12 gives 6 and 13 gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; preload is enabled while it is low |
| load_en | input | 1 | Preload write strobe (only honoured during reset) |
| load_addr | input | 5 | Preload word address |
| load_data | input | 8 | Preload word value |
| peek_addr | input | 5 | Read-back word address |
| peek_data | output | 8 | Memory word at `peek_addr` |
| acc_out | output | 8 | Accumulator A |
| opb_out | output | 8 | Operand register B |
| pc_out | output | 4 | Program counter |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
A wrong serial carry or a misaligned bit counter shows up in `opb_out` or `acc_out` as soon as the flag clock of the affected subtract or decrement is over, ten clocks after its fetch. A flag that is set wrongly shows only when a later skip acts on it: one instruction is stored or dropped by mistake, which is visible through `peek_data` once the program halts. Control errors in jump or skip handling move `pc_out` away from the predicted halt address. They also move the halt cycle in the timed test, so the factor runs show most internal faults within a few hundred clocks.

// File: rtl/sac_pkg.sv
package sac_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_NOP  = 4'h0,
        OP_LD   = 4'h1,
        OP_ST   = 4'h2,
        OP_MV   = 4'h3,
        OP_DEC  = 4'h4,
        OP_SUB  = 4'h5,
        OP_SKNE = 4'h6,
        OP_SKLT = 4'h7,
        OP_JMP  = 4'h8,
        OP_HLT  = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        S_FETCH,
        S_EXEC,
        S_SER,
        S_FLAG,
        S_HALT
    } st_e;

endpackage

// File: rtl/sac_store.sv
module sac_store #(
    parameter int DW  = 8,
    parameter int MAW = 5
) (
    input  logic           clk,
    input  logic           we,
    input  logic [MAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [MAW-1:0] raddr,
    output logic [DW-1:0]  rdata,
    input  logic [MAW-1:0] paddr,
    output logic [DW-1:0]  pdata
);
    localparam int DEPTH = 2 ** MAW;

    logic [DW-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words_q[waddr] <= wdata;
        end
    end

    assign rdata = words_q[raddr];
    assign pdata = words_q[paddr];

endmodule

// File: rtl/sac_fa.sv
module sac_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    assign s  = x ^ y ^ ci;
    assign co = (x & y) | (x & ci) | (y & ci);
endmodule

// File: rtl/serial_acc_cpu.sv
module serial_acc_cpu #(
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_en,
    input  logic [DW-4:0]         load_addr,
    input  logic [DW-1:0]         load_data,
    input  logic [DW-4:0]         peek_addr,
    output logic [DW-1:0]         peek_data,
    output logic [DW-1:0]         acc_out,
    output logic [DW-1:0]         opb_out,
    output logic [DW-5:0]         pc_out,
    output logic                  halted
);
    import sac_pkg::*;

    localparam int AW  = DW - OPW;
    localparam int MAW = AW + 1;
    localparam int CW  = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] pc;
        logic [DW-1:0] ir;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [CW-1:0] cnt;
        logic          cy;
        logic          zacc;
        logic          zf;
        logic          nf;
    } core_t;

    localparam core_t RST_VAL = '{st: S_FETCH, pc: '0, ir: '0, a: '0, b: '0,
                                  cnt: '0, cy: 1'b0, zacc: 1'b0, zf: 1'b1, nf: 1'b0};

    core_t core_d, core_q;

    logic           core_we;
    logic [MAW-1:0] mem_raddr;
    logic [DW-1:0]  mem_rd;
    logic           mem_we;
    logic [MAW-1:0] mem_waddr;
    logic [DW-1:0]  mem_wdata;
    op_e            op;
    op_e            fop;
    logic [AW-1:0]  field;
    logic           is_sub;
    logic           fa_x, fa_y, fa_s, fa_co;

    assign op     = op_e'(core_q.ir[DW-1:AW]);
    assign field  = core_q.ir[AW-1:0];
    assign fop    = op_e'(mem_rd[DW-1:AW]);
    assign is_sub = (op == OP_SUB);

    assign mem_raddr = (core_q.st == S_FETCH) ? {1'b0, core_q.pc} : {1'b1, field};
    assign mem_we    = rst_n ? core_we : load_en;
    assign mem_waddr = rst_n ? {1'b1, field} : load_addr;
    assign mem_wdata = rst_n ? core_q.a : load_data;

    sac_store #(.DW(DW), .MAW(MAW)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rd),
        .paddr (peek_addr),
        .pdata (peek_data)
    );

    // Subtract: B + ~A + 1 (carry preset to 1). Decrement: A + all-ones.
    assign fa_x = is_sub ? core_q.b[0] : core_q.a[0];
    assign fa_y = is_sub ? ~core_q.a[0] : 1'b1;

    sac_fa u_fa (
        .x  (fa_x),
        .y  (fa_y),
        .ci (core_q.cy),
        .s  (fa_s),
        .co (fa_co)
    );

    always_comb begin
        core_d  = core_q;
        core_we = 1'b0;
        unique case (core_q.st)
            S_FETCH: begin
                core_d.ir = mem_rd;
                core_d.pc = core_q.pc + 1'b1;
                if (fop == OP_DEC || fop == OP_SUB) begin
                    core_d.st   = S_SER;
                    core_d.cnt  = '0;
                    core_d.cy   = (fop == OP_SUB);
                    core_d.zacc = 1'b0;
                end else begin
                    core_d.st = S_EXEC;
                end
            end
            S_EXEC: begin
                core_d.st = S_FETCH;
                case (op)
                    OP_LD:   core_d.a = mem_rd;
                    OP_ST:   core_we = 1'b1;
                    OP_MV:   core_d.b = core_q.a;
                    OP_SKNE: if (!core_q.zf) core_d.pc = core_q.pc + 1'b1;
                    OP_SKLT: if (core_q.nf)  core_d.pc = core_q.pc + 1'b1;
                    OP_JMP:  core_d.pc = field;
                    OP_HLT:  core_d.st = S_HALT;
                    default: ;
                endcase
            end
            S_SER: begin
                core_d.cy   = fa_co;
                core_d.zacc = core_q.zacc | fa_s;
                if (is_sub) begin
                    core_d.b = {fa_s, core_q.b[DW-1:1]};
                    core_d.a = {core_q.a[0], core_q.a[DW-1:1]};
                end else begin
                    core_d.a = {fa_s, core_q.a[DW-1:1]};
                end
                core_d.cnt = core_q.cnt + 1'b1;
                if (core_q.cnt == LAST_BIT) begin
                    core_d.st = S_FLAG;
                end
            end
            S_FLAG: begin
                if (is_sub) begin
                    core_d.zf = ~core_q.zacc;
                    core_d.nf = ~core_q.cy;
                end
                core_d.st = S_FETCH;
            end
            S_HALT: core_d.st = S_HALT;
            default: core_d.st = S_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= RST_VAL;
        end else begin
            core_q <= core_d;
        end
    end

    assign acc_out = core_q.a;
    assign opb_out = core_q.b;
    assign pc_out  = core_q.pc;
    assign halted  = (core_q.st == S_HALT);

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R9
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(pc_out) && $stable(acc_out) && $stable(opb_out) && !mem_we)); // R9
    AST_MV_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == S_EXEC && op == OP_MV) |=> (opb_out == $past(acc_out))); // R3
    AST_LD_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == S_EXEC && op == OP_LD) |=> (acc_out == $past(mem_rd))); // R2
    AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == S_EXEC && op == OP_JMP) |=> (pc_out == $past(field))); // R8
    AST_FLAG_AFTER_SER: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == S_FLAG) |-> ($past(core_q.st) == S_SER)); // R10

endmodule

// File: tb/serial_acc_cpu_bench.sv
module serial_acc_cpu_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [4:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic [4:0] peek_addr = '0;
    logic [7:0] peek_data, acc_out, opb_out;
    logic [3:0] pc_out;
    logic       halted;

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    serial_acc_cpu u_serial_acc_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .peek_addr (peek_addr),
        .peek_data (peek_data),
        .acc_out   (acc_out),
        .opb_out   (opb_out),
        .pc_out    (pc_out),
        .halted    (halted)
    );

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                nvec++;
                nfail++;
                $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
                summary();
                $finish;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ins(input logic [3:0] op, input logic [3:0] f);
        return {op, f};
    endfunction

    task automatic put(input int ad, input logic [7:0] d);
        load_en   = 1'b1;
        load_addr = ad[4:0];
        load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic load_begin;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 32; i++) put(i, 8'h00);
    endtask

    task automatic peek(input int ad, output int d);
        peek_addr = ad[4:0];
        #1;
        d = int'(peek_data);
    endtask

    task automatic run(input string tag, output int n);
        n = 0;
        rst_n = 1'b1;
        while (!halted && n < 20000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        check({tag, " reached halt"}, int'(halted), 1);
    endtask

    task automatic t_reset;
        int d;
        int n;
        load_begin();
        put(16, 8'h11);
        put(0, ins(4'hF, 4'h0));
        run("R1 prerun", n);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 halted cleared by reset", int'(halted), 0);
        check("R1 pc at reset", int'(pc_out), 0);
        check("R1 acc at reset", int'(acc_out), 0);
        check("R1 opb at reset", int'(opb_out), 0);
        put(20, 8'hA7);
        peek(20, d);
        check("R1 preload readback", d, 8'hA7);
    endtask

    task automatic t_ld_mv_st;
        int d;
        int n;
        load_begin();
        put(18, 8'h5A);
        put(0, ins(4'h1, 4'h2));
        put(1, ins(4'h3, 4'h0));
        put(2, ins(4'h2, 4'h3));
        put(3, ins(4'hF, 4'h0));
        run("R2", n);
        check("R2 load into A", int'(acc_out), 8'h5A);
        check("R3 move A to B", int'(opb_out), 8'h5A);
        peek(19, d);
        check("R2 store to data word 3", d, 8'h5A);
        check("R9 pc after halt", int'(pc_out), 4);
    endtask

    task automatic t_dec_wrap;
        int n;
        load_begin();
        put(0, ins(4'h1, 4'h0));
        put(1, ins(4'h4, 4'h0));
        put(2, ins(4'hF, 4'h0));
        run("R4", n);
        check("R4 decrement wraps 0 to FF", int'(acc_out), 8'hFF);
        check("R10 clocks to halt LD+DEC+HLT", n, 14);
    endtask

    task automatic t_sub(input logic [7:0] bv, input logic [7:0] av);
        int n;
        load_begin();
        put(16, bv);
        put(17, av);
        put(0, ins(4'h1, 4'h0));
        put(1, ins(4'h3, 4'h0));
        put(2, ins(4'h1, 4'h1));
        put(3, ins(4'h5, 4'h0));
        put(4, ins(4'h0, 4'h0));
        put(5, ins(4'hF, 4'h0));
        run("R5", n);
        check("R5 B minus A", int'(opb_out), int'(8'(bv - av)));
        check("R5 A unchanged", int'(acc_out), int'(av));
        check("R10 R3 clocks with a nop", n, 2 + 2 + 2 + 10 + 2 + 2);
    endtask

    task automatic t_skip(input string tag, input logic [3:0] skop,
                          input logic [7:0] bv, input logic [7:0] av,
                          input int exp_store);
        int d;
        int n;
        load_begin();
        put(16, bv);
        put(17, av);
        put(0, ins(4'h1, 4'h0));
        put(1, ins(4'h3, 4'h0));
        put(2, ins(4'h1, 4'h1));
        put(3, ins(4'h5, 4'h0));
        put(4, ins(skop, 4'h0));
        put(5, ins(4'h2, 4'h5));
        put(6, ins(4'hF, 4'h0));
        run(tag, n);
        peek(21, d);
        check(tag, d, exp_store);
        check({tag, " pc"}, int'(pc_out), 7);
    endtask

    task automatic t_jmp;
        int d;
        int n;
        load_begin();
        put(16, 8'h3C);
        put(0, ins(4'h1, 4'h0));
        put(1, ins(4'h8, 4'h4));
        put(2, ins(4'h2, 4'h6));
        put(3, ins(4'hF, 4'h0));
        put(4, ins(4'h2, 4'h7));
        put(5, ins(4'hF, 4'h0));
        run("R8", n);
        peek(23, d);
        check("R8 jump target executed", d, 8'h3C);
        peek(22, d);
        check("R8 jumped-over store skipped", d, 0);
        check("R8 pc after halt", int'(pc_out), 6);
    endtask

    task automatic t_halt;
        int d;
        int n;
        load_begin();
        put(16, 8'h77);
        put(0, ins(4'h1, 4'h0));
        put(1, ins(4'hF, 4'h0));
        put(2, ins(4'h2, 4'h1));
        run("R9", n);
        for (int i = 0; i < 30; i++) @(negedge clk);
        check("R9 halted stays high", int'(halted), 1);
        check("R9 pc frozen", int'(pc_out), 2);
        check("R9 acc frozen", int'(acc_out), 8'h77);
        peek(17, d);
        check("R9 no store after halt", d, 0);
    endtask

    task automatic t_factor(input logic [7:0] x, input int exp);
        int d;
        int n;
        load_begin();
        put(16, x);
        put(0,  ins(4'h1, 4'h0));
        put(1,  ins(4'h3, 4'h0));
        put(2,  ins(4'h4, 4'h0));
        put(3,  ins(4'h2, 4'h1));
        put(4,  ins(4'h1, 4'h0));
        put(5,  ins(4'h3, 4'h0));
        put(6,  ins(4'h1, 4'h1));
        put(7,  ins(4'h5, 4'h0));
        put(8,  ins(4'h6, 4'h0));
        put(9,  ins(4'hF, 4'h0));
        put(10, ins(4'h7, 4'h0));
        put(11, ins(4'h8, 4'h7));
        put(12, ins(4'h1, 4'h1));
        put(13, ins(4'h8, 4'h1));
        run("R11", n);
        peek(17, d);
        check("R11 factor in data word 1", d, exp);
        check("R11 factor in A", int'(acc_out), exp);
        check("R11 B zero at halt", int'(opb_out), 0);
        check("R11 halt address", int'(pc_out), 10);
    endtask

    initial begin
        t_reset();
        t_ld_mv_st();
        t_dec_wrap();
        t_sub(8'h30, 8'h12);
        t_sub(8'h12, 8'h30);
        t_skip("R6 zero result no skip", 4'h6, 8'h44, 8'h44, 8'h44);
        t_skip("R6 nonzero result skips", 4'h6, 8'h44, 8'h01, 0);
        t_skip("R7 negative result skips", 4'h7, 8'h05, 8'h09, 0);
        t_skip("R7 equal operands no skip", 4'h7, 8'h05, 8'h05, 8'h05);
        t_jmp();
        t_halt();
        t_factor(8'd21, 7);
        t_factor(8'd12, 6);
        t_factor(8'd13, 1);
        summary();
        $finish;
    end

endmodule